// File: doc/BRIEF.md
# Piecewise-Linear Transfer Curve

This block applies a programmable transfer curve to each colour channel of a pixel stream. Each of the three channels (red, green, blue) owns a table of knee points. A 10-bit input sample selects a segment between two neighbouring knees, and the output is found by linear interpolation between them. When a channel is not enabled, its sample passes through unchanged, widened to the output width.

The three tables sit back to back in one storage array and are loaded through two configuration ports. Writing the address port positions a load pointer. Each write to the data port then stores two 16-bit knees and moves the pointer on by two, so a complete table set streams in with one address write and a run of data writes. The table length is a build-time parameter: 33 knees per channel, or 41 knees per channel. In the 41-knee build, the interpolated span uses the 33 central knees, and the four knees at each end hold the curve's clamped floor and ceiling. A separate control write selects which channels use their curve.

Top module: `pwl_curve_lut`

## Requirements
- R1: A write on the address port loads the load pointer. A data-port write with the pointer at p stores data bits 15:0 at entry p and bits 31:16 at entry p+1, then moves the pointer to p+2. When the address port and the data port are written in the same cycle, the address write wins and the data is dropped.
- R2: Storage is one array of 3*N entries, where N is the number of knees per channel. Red uses entries 0..N-1, green uses N..2N-1 and blue uses 2N..3N-1. A single data write may straddle a channel boundary; for example, at pointer N-1 it sets the last red knee and the first green knee.
- R3: The pointer never exceeds 3*N. A data write moves it to 3*N when it would pass the end. The upper half of a write at pointer 3*N-1 is discarded. Data writes at pointer 3*N change no entry. An address value of 3*N or more is clamped to 3*N.
- R4: A control write takes three enable bits starting at bit L: red at L, green at L+1, blue at L+2. L is 27 when N is 33 and 29 when N is 41. All other control bits are ignored. The enables are clear after reset.
- R5: A channel whose enable is clear outputs its 10-bit sample zero-extended to 16 bits.
- R6: An enabled channel with sample x uses knee index k = O + x[9:5], where O = (N-33)/2, and fraction f = x[4:0]. Its output is e[k] + floor((e[k+1]-e[k])*f/32), where the difference is signed. A 33-knee table with e[i] = i*0x200 therefore returns x*16.
- R7: out_valid rises exactly two clock cycles after in_valid. The outputs change only on a cycle in which out_valid is 1, and they hold otherwise.
- R8: When a sample is accepted in the same cycle as a data write, the sample is looked up in the table as it stood before that write. The next sample sees the new contents.
- R9: During and after reset, out_valid is 0 and all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_we | input | 1 | Load-pointer write strobe |
| cfg_addr | input | 8 | New load-pointer value |
| cfg_data_we | input | 1 | Table data write strobe |
| cfg_data | input | 32 | Two knees: lower index in 15:0, next index in 31:16 |
| cfg_ctrl_we | input | 1 | Control write strobe |
| cfg_ctrl | input | 32 | Control word carrying the three channel enables |
| in_valid | input | 1 | Input sample valid |
| in_r | input | 10 | Red sample |
| in_g | input | 10 | Green sample |
| in_b | input | 10 | Blue sample |
| out_valid | output | 1 | Output valid, two cycles after in_valid |
| out_r | output | 16 | Red result |
| out_g | output | 16 | Green result |
| out_b | output | 16 | Blue result |

## Verification
The hardest case to reach is the edge of the storage array. To get there, the pointer has to be walked, or set, right up to the last blue knee. The stimulus must then show that the discarded upper half of the final write, and any later writes, leave both that knee and the first red knee untouched. The bench places a write at the last entry, follows it with a write into the saturated pointer and then an out-of-range address, and reads the two extreme knees back through samples 1023 and 0. A second hard case is a table write and a sample in the same cycle. The bench drives both strobes on one edge and compares the result against the value the knee held before the write.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

  localparam int NCH = 3;

  typedef enum logic [1:0] {
    CH_RED = 2'd0,
    CH_GRN = 2'd1,
    CH_BLU = 2'd2
  } chan_e;

  // Lowest bit of the three enable bits in the control word.
  function automatic int enable_lsb(input int npts);
    return (npts == 33) ? 27 : 29;
  endfunction

  // Knees held at each end outside the interpolated span.
  function automatic int knee_offset(input int npts, input int nseg);
    return (npts - 1 - nseg) / 2;
  endfunction

endpackage

// File: rtl/pwl_loader.sv
module pwl_loader #(
  parameter int NPTS   = 33,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(3 * NPTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              data_we,
  output logic [IDX_W-1:0]  ptr,
  output logic              wr0_en,
  output logic [IDX_W-1:0]  wr0_idx,
  output logic              wr1_en,
  output logic [IDX_W-1:0]  wr1_idx
);

  localparam int TOTAL = 3 * NPTS;
  localparam logic [IDX_W-1:0] PTR_END = IDX_W'(TOTAL);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             ptr_ce;
  logic             room;

  assign room = (ptr_q < PTR_END);

  // Write strobes for the two halves of a data word.
  always_comb begin
    wr0_en  = data_we && !addr_we && room;
    wr0_idx = ptr_q;
    wr1_en  = wr0_en && (ptr_q < PTR_END - IDX_W'(1));
    wr1_idx = ptr_q + IDX_W'(1);
  end

  // Next pointer value.
  always_comb begin
    ptr_d  = ptr_q;
    ptr_ce = 1'b0;
    if (addr_we) begin
      ptr_ce = 1'b1;
      if (addr >= ADDR_W'(TOTAL)) ptr_d = PTR_END;
      else                        ptr_d = addr[IDX_W-1:0];
    end else if (wr0_en) begin
      ptr_ce = 1'b1;
      if (ptr_q >= PTR_END - IDX_W'(2)) ptr_d = PTR_END;
      else                              ptr_d = ptr_q + IDX_W'(2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_ce) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/pwl_table.sv
module pwl_table
  import pwl_pkg::*;
#(
  parameter int NPTS    = 33,
  parameter int ENTRY_W = 16,
  parameter int IDX_W   = $clog2(3 * NPTS + 1),
  parameter int KNEE_W  = $clog2(NPTS)
) (
  input  logic                          clk,
  input  logic                          wr0_en,
  input  logic [IDX_W-1:0]              wr0_idx,
  input  logic [ENTRY_W-1:0]            wr0_data,
  input  logic                          wr1_en,
  input  logic [IDX_W-1:0]              wr1_idx,
  input  logic [ENTRY_W-1:0]            wr1_data,
  input  logic [NCH-1:0][KNEE_W-1:0]    rd_knee,
  output logic [NCH-1:0][ENTRY_W-1:0]   rd_lo,
  output logic [NCH-1:0][ENTRY_W-1:0]   rd_hi
);

  localparam int TOTAL = 3 * NPTS;

  // Knee storage without reset; contents are loaded before use.
  logic [ENTRY_W-1:0] mem [TOTAL];

  always_ff @(posedge clk) begin
    if (wr0_en) mem[wr0_idx] <= wr0_data;
    if (wr1_en) mem[wr1_idx] <= wr1_data;
  end

  // One pair of neighbouring knees per channel, read combinationally.
  for (genvar c = 0; c < NCH; c++) begin : g_rd
    logic [IDX_W-1:0] idx_lo, idx_hi;
    assign idx_lo   = IDX_W'(c * NPTS) + IDX_W'(rd_knee[c]);
    assign idx_hi   = idx_lo + IDX_W'(1);
    assign rd_lo[c] = mem[idx_lo];
    assign rd_hi[c] = mem[idx_hi];
  end

endmodule

// File: rtl/pwl_interp.sv
module pwl_interp
  import pwl_pkg::*;
#(
  parameter int NPTS     = 33,
  parameter int SAMPLE_W = 10,
  parameter int SEG_W    = 5,
  parameter int ENTRY_W  = 16,
  parameter int KNEE_W   = $clog2(NPTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s0_valid,
  input  logic                s1_valid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                enable,
  output logic [KNEE_W-1:0]   knee,
  input  logic [ENTRY_W-1:0]  knee_lo,
  input  logic [ENTRY_W-1:0]  knee_hi,
  output logic [ENTRY_W-1:0]  result
);

  localparam int FRAC_W = SAMPLE_W - SEG_W;
  localparam int OFS    = knee_offset(NPTS, 2 ** SEG_W);
  localparam int DW     = ENTRY_W + 1;
  localparam int PRW    = DW + FRAC_W + 1;

  // Stage 0: knee index from the upper sample bits.
  assign knee = KNEE_W'(OFS) + KNEE_W'(sample[SAMPLE_W-1 -: SEG_W]);

  // Stage 1 registers.
  logic [ENTRY_W-1:0]  lo1_q, hi1_q;
  logic [FRAC_W-1:0]   frac1_q;
  logic [SAMPLE_W-1:0] samp1_q;
  logic                en1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo1_q   <= '0;
      hi1_q   <= '0;
      frac1_q <= '0;
      samp1_q <= '0;
      en1_q   <= 1'b0;
    end else if (s0_valid) begin
      lo1_q   <= knee_lo;
      hi1_q   <= knee_hi;
      frac1_q <= sample[FRAC_W-1:0];
      samp1_q <= sample;
      en1_q   <= enable;
    end
  end

  // Stage 1 arithmetic: lo + floor((hi - lo) * frac / 2^FRAC_W).
  logic signed [DW-1:0]  diff;
  logic signed [PRW-1:0] diff_x, frac_x, prod, step, sum;
  logic [PRW-ENTRY_W-1:0] sum_unused;
  logic [ENTRY_W-1:0]    res_d;

  always_comb begin
    diff   = $signed({1'b0, hi1_q}) - $signed({1'b0, lo1_q});
    diff_x = PRW'(diff);
    frac_x = PRW'($signed({1'b0, frac1_q}));
    prod   = diff_x * frac_x;
    step   = prod >>> FRAC_W;
    sum    = PRW'($signed({1'b0, lo1_q})) + step;
    res_d  = en1_q ? sum[ENTRY_W-1:0] : ENTRY_W'(samp1_q);
  end

  assign sum_unused = sum[PRW-1:ENTRY_W];

  // Stage 2 register.
  logic [ENTRY_W-1:0] res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (s1_valid) res_q <= res_d;
  end

  assign result = res_q;

endmodule

// File: rtl/pwl_curve_lut.sv
module pwl_curve_lut
  import pwl_pkg::*;
#(
  parameter int NPTS     = 33,
  parameter int SAMPLE_W = 10,
  parameter int SEG_W    = 5,
  parameter int ENTRY_W  = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_addr_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic                cfg_data_we,
  input  logic [DATA_W-1:0]   cfg_data,
  input  logic                cfg_ctrl_we,
  input  logic [31:0]         cfg_ctrl,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_r,
  input  logic [SAMPLE_W-1:0] in_g,
  input  logic [SAMPLE_W-1:0] in_b,
  output logic                out_valid,
  output logic [ENTRY_W-1:0]  out_r,
  output logic [ENTRY_W-1:0]  out_g,
  output logic [ENTRY_W-1:0]  out_b
);

  localparam int IDX_W  = $clog2(3 * NPTS + 1);
  localparam int KNEE_W = $clog2(NPTS);
  localparam int EN_LSB = enable_lsb(NPTS);

  // Channel enables.
  logic [NCH-1:0] en_q, en_d;
  logic           ctrl_unused;

  assign en_d        = cfg_ctrl[EN_LSB +: NCH];
  assign ctrl_unused = ^cfg_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           en_q <= '0;
    else if (cfg_ctrl_we) en_q <= en_d;
  end

  // Valid pipeline.
  logic v1_q, v2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
    end
  end

  // Loader.
  logic [IDX_W-1:0] ptr_q;
  logic             wr0_en, wr1_en;
  logic [IDX_W-1:0] wr0_idx, wr1_idx;

  pwl_loader #(
    .NPTS(NPTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_loader (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_we (cfg_addr_we),
    .addr    (cfg_addr),
    .data_we (cfg_data_we),
    .ptr     (ptr_q),
    .wr0_en  (wr0_en),
    .wr0_idx (wr0_idx),
    .wr1_en  (wr1_en),
    .wr1_idx (wr1_idx)
  );

  // Table.
  logic [NCH-1:0][KNEE_W-1:0]  knee;
  logic [NCH-1:0][ENTRY_W-1:0] knee_lo, knee_hi, res;
  logic [NCH-1:0][SAMPLE_W-1:0] smp;

  assign smp[CH_RED] = in_r;
  assign smp[CH_GRN] = in_g;
  assign smp[CH_BLU] = in_b;

  pwl_table #(
    .NPTS(NPTS), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W), .KNEE_W(KNEE_W)
  ) u_table (
    .clk      (clk),
    .wr0_en   (wr0_en),
    .wr0_idx  (wr0_idx),
    .wr0_data (cfg_data[ENTRY_W-1:0]),
    .wr1_en   (wr1_en),
    .wr1_idx  (wr1_idx),
    .wr1_data (cfg_data[2*ENTRY_W-1:ENTRY_W]),
    .rd_knee  (knee),
    .rd_lo    (knee_lo),
    .rd_hi    (knee_hi)
  );

  // One interpolator per channel.
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwl_interp #(
      .NPTS(NPTS), .SAMPLE_W(SAMPLE_W), .SEG_W(SEG_W),
      .ENTRY_W(ENTRY_W), .KNEE_W(KNEE_W)
    ) u_interp (
      .clk      (clk),
      .rst_n    (rst_n),
      .s0_valid (in_valid),
      .s1_valid (v1_q),
      .sample   (smp[c]),
      .enable   (en_q[c]),
      .knee     (knee[c]),
      .knee_lo  (knee_lo[c]),
      .knee_hi  (knee_hi[c]),
      .result   (res[c])
    );
  end

  assign out_valid = v2_q;
  assign out_r     = res[CH_RED];
  assign out_g     = res[CH_GRN];
  assign out_b     = res[CH_BLU];

endmodule

// File: rtl/pwl_curve_lut_chk.sv
module pwl_curve_lut_chk #(
  parameter int NPTS    = 33,
  parameter int ENTRY_W = 16,
  parameter int IDX_W   = $clog2(3 * NPTS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               out_valid,
  input logic [ENTRY_W-1:0] out_r,
  input logic [ENTRY_W-1:0] out_g,
  input logic [ENTRY_W-1:0] out_b,
  input logic               cfg_addr_we,
  input logic               cfg_data_we,
  input logic [IDX_W-1:0]   ptr_q,
  input logic               wr0_en
);

  localparam logic [IDX_W-1:0] PEND = IDX_W'(3 * NPTS);

  AST_LAT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid); // R7

  AST_LAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_r) && $stable(out_g) && $stable(out_b))); // R7

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PEND); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_data_we && !cfg_addr_we && (ptr_q < PEND - IDX_W'(2)))
    |=> (ptr_q == $past(ptr_q) + IDX_W'(2))); // R1

  AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_data_we && (ptr_q == PEND)) |-> !wr0_en); // R3

endmodule

bind pwl_curve_lut pwl_curve_lut_chk #(
  .NPTS(NPTS), .ENTRY_W(ENTRY_W), .IDX_W($clog2(3 * NPTS + 1))
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_r       (out_r),
  .out_g       (out_g),
  .out_b       (out_b),
  .cfg_addr_we (cfg_addr_we),
  .cfg_data_we (cfg_data_we),
  .ptr_q       (ptr_q),
  .wr0_en      (wr0_en)
);

// File: tb/sim_pwl_curve_lut.sv
module sim_pwl_curve_lut;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 33;
  localparam int TOT = 3 * N;
  localparam int ENL = 27;

  logic        clk, rst_n;
  logic        cfg_addr_we, cfg_data_we, cfg_ctrl_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_data, cfg_ctrl;
  logic        in_valid;
  logic [9:0]  in_r, in_g, in_b;
  logic        out_valid;
  logic [15:0] out_r, out_g, out_b;

  pwl_curve_lut #(.NPTS(N)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr_we(cfg_addr_we), .cfg_addr(cfg_addr),
    .cfg_data_we(cfg_data_we), .cfg_data(cfg_data),
    .cfg_ctrl_we(cfg_ctrl_we), .cfg_ctrl(cfg_ctrl),
    .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int mdl [TOT];
  int want [TOT];
  int bp = 0;
  logic [2:0] en_m = 3'b000;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_ch(input int c, input int x, input bit en);
    int k, f, lo, hi;
    if (!en) return x;
    k  = x >> 5;
    f  = x & 31;
    lo = mdl[c * N + k];
    hi = mdl[c * N + k + 1];
    return lo + (((hi - lo) * f) >>> 5);
  endfunction

  task automatic wr_addr(input int a);
    @(negedge clk);
    cfg_addr_we = 1'b1;
    cfg_addr    = 8'(a);
    @(negedge clk);
    cfg_addr_we = 1'b0;
    bp = (a >= TOT) ? TOT : a;
  endtask

  task automatic wr_data(input int lo, input int hi);
    @(negedge clk);
    cfg_data_we = 1'b1;
    cfg_data    = {16'(hi), 16'(lo)};
    @(negedge clk);
    cfg_data_we = 1'b0;
    if (bp < TOT) begin
      mdl[bp] = lo;
      if (bp + 1 < TOT) mdl[bp + 1] = hi;
      bp = (bp + 2 > TOT) ? TOT : bp + 2;
    end
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk);
    cfg_ctrl_we = 1'b1;
    cfg_ctrl    = v;
    @(negedge clk);
    cfg_ctrl_we = 1'b0;
    en_m = v[ENL +: 3];
  endtask

  task automatic load_want();
    wr_addr(0);
    for (int w = 0; w < (TOT + 1) / 2; w++)
      wr_data(want[2 * w], (2 * w + 1 < TOT) ? want[2 * w + 1] : 0);
  endtask

  task automatic send(input int r, input int g, input int b, input string req);
    int er, eg, eb;
    er = expect_ch(0, r, en_m[0]);
    eg = expect_ch(1, g, en_m[1]);
    eb = expect_ch(2, b, en_m[2]);
    @(negedge clk);
    in_valid = 1'b1;
    in_r = 10'(r); in_g = 10'(g); in_b = 10'(b);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " red"},   int'(out_r), er);
    chk({req, " green"}, int'(out_g), eg);
    chk({req, " blue"},  int'(out_b), eb);
  endtask

  // R9 R4 R5: reset state, then bypass with enables clear.
  task automatic t_reset();
    chk("R9 out_valid", int'(out_valid), 0);
    chk("R9 out_r", int'(out_r), 0);
    chk("R9 out_g", int'(out_g), 0);
    chk("R9 out_b", int'(out_b), 0);
    send(5, 700, 1023, "R4 R5 bypass after reset");
  endtask

  // R2 R6: identity table gives x*16 on every channel.
  task automatic t_identity();
    for (int i = 0; i < TOT; i++) want[i] = (i % N) * 'h200;
    load_want();
    wr_ctrl(32'(7) << ENL);
    chk("R6 identity 0", expect_ch(0, 517, 1'b1), 517 * 16);
    send(0, 1, 31, "R6 identity a");
    send(32, 517, 1023, "R6 identity b");
    send(1000, 33, 64, "R6 identity c");
  endtask

  // R2 R6: distinct curves per channel, including falling slope.
  task automatic t_curves();
    for (int i = 0; i < N; i++) begin
      want[i]         = i * 'h200;
      want[N + i]     = 'h4000 - i * 'h200;
      want[2 * N + i] = i * i * 16;
    end
    load_want();
    send(17, 17, 17, "R2 R6 curves a");
    send(523, 801, 999, "R2 R6 curves b");
    send(1023, 1023, 1023, "R2 R6 curves c");
  endtask

  // R1 R2: write straddling the red/green boundary.
  task automatic t_straddle();
    wr_addr(N - 1);
    wr_data(16'h1111, 16'h2222);
    chk("R2 model red last", mdl[N - 1], 16'h1111);
    send(1023, 0, 0, "R1 R2 straddle a");
    send(1000, 20, 3, "R1 R2 straddle b");
  endtask

  // R3: end of array, saturated pointer, clamped address.
  task automatic t_end();
    wr_addr(TOT - 1);
    wr_data(16'h1234, 16'hAAAA);
    wr_data(16'h5555, 16'h6666);
    wr_addr(200);
    wr_data(16'h7777, 16'h7777);
    chk("R3 model last", mdl[TOT - 1], 16'h1234);
    send(0, 500, 1023, "R3 end of table");
    // R1: address and data in one cycle, data dropped.
    @(negedge clk);
    cfg_addr_we = 1'b1; cfg_addr = 8'd0;
    cfg_data_we = 1'b1; cfg_data = 32'h0BAD0BAD;
    @(negedge clk);
    cfg_addr_we = 1'b0; cfg_data_we = 1'b0;
    bp = 0;
    send(0, 0, 0, "R1 addr wins");
  endtask

  // R4 R5: only green enabled, other control bits set.
  task automatic t_bypass();
    wr_ctrl((32'(2) << ENL) | 32'h8000_0001 | 32'h0400_0000);
    chk("R4 enable model", int'(en_m), 2);
    send(300, 300, 300, "R4 R5 green only");
    wr_ctrl(32'h0);
    send(1023, 64, 9, "R4 R5 all bypass");
    wr_ctrl(32'(7) << ENL);
  endtask

  // R8: data write and sample in the same cycle.
  task automatic t_collide();
    int old_r;
    wr_addr(0);
    old_r = expect_ch(0, 0, 1'b1);
    @(negedge clk);
    cfg_data_we = 1'b1; cfg_data = {16'h0100, 16'h0777};
    in_valid = 1'b1; in_r = 10'd0; in_g = 10'd0; in_b = 10'd0;
    @(negedge clk);
    cfg_data_we = 1'b0; in_valid = 1'b0;
    mdl[0] = 16'h0777; mdl[1] = 16'h0100; bp = 2;
    @(negedge clk);
    chk("R8 old table", int'(out_r), old_r);
    send(0, 0, 0, "R8 new table");
  endtask

  // R7: latency and hold.
  task automatic t_latency();
    int held;
    @(negedge clk);
    in_valid = 1'b1; in_r = 10'd40; in_g = 10'd41; in_b = 10'd42;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 not yet", int'(out_valid), 0);
    @(negedge clk);
    chk("R7 valid at two", int'(out_valid), 1);
    held = int'(out_g);
    in_g = 10'd900;
    @(negedge clk);
    chk("R7 valid drops", int'(out_valid), 0);
    @(negedge clk);
    chk("R7 hold", int'(out_g), held);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_addr_we = 1'b0; cfg_addr = '0;
    cfg_data_we = 1'b0; cfg_data = '0;
    cfg_ctrl_we = 1'b0; cfg_ctrl = '0;
    in_valid = 1'b0; in_r = '0; in_g = '0; in_b = '0;
    for (int i = 0; i < TOT; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_curves();
    t_straddle();
    t_end();
    t_bypass();
    t_collide();
    t_latency();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule